// File: doc/BRIEF.md
# Calendar Clock with Daylight-Saving Adjustment

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day of week, date, month and a two-digit year as binary counters, and advances them by one second on each pulse of a one-second tick input. On each tick it also copies the new time into a host-visible buffer and raises a one-clock update-ended pulse. A control bit can block that copy. The counters keep running while the copy is blocked, and the host sees the current time again at the first tick after the block is lifted.

The host reaches the block through one byte-wide register port. Addresses 0 to 6 are the time bytes and address 7 is the control byte. Bytes are shown and accepted in BCD or in plain binary, and hours in 24-hour or 12-hour form. Both choices can change at any time, because the stored value is always binary and is converted on each read and write. When the daylight-saving bit is set, the clock skips forward one hour on the first Sunday of April. On the last Sunday of October it repeats the 1 AM hour, and it does so only once that night.

Top module: `rtc_calendar`

## Requirements
- R1: Counters roll over as a calendar does. Seconds and minutes run 0..59 and hours run 0..23. Day of week runs 1..7 with 1 = Sunday and wraps from 7 to 1. The date wraps to 1 after the last day of the month: 30 days for months 4, 6, 9 and 11, 31 days for the other months, and 29 days in February when year mod 4 = 0 (otherwise 28). The month wraps from 12 to 1 and the year from 99 to 0.
- R2: On a clock where `sec_tick` is 1 and the inhibit bit is 0, the buffer takes the advanced time. `upd_done` is 1 during the following clock only. The reset state of `upd_done` is 0.
- R3: While control bit 7 (inhibit) is 1, ticks leave the buffer unchanged and raise no `upd_done`, but the counters still advance. The first tick after bit 7 returns to 0 transfers the fully advanced time.
- R4: A control write with bit 7 = 1 stores bit 4 (update-interrupt enable) as 0. Bit 4 therefore never reads 1 while bit 7 reads 1.
- R5: Control layout: bit 7 inhibit, bit 6 periodic enable, bit 5 alarm enable, bit 4 update enable, bit 2 data format, bit 1 hour format, bit 0 daylight-saving enable. Bit 3 always reads 0 and every other bit reads back as written. The control byte resets to 0x00.
- R6: Address map: 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year, 7 control. `reg_rdata` is registered and shows the byte for the `reg_addr` of the previous clock. When control bit 2 is 0, time bytes are read and written as two BCD digits (tens in bits 7:4). When it is 1, they are plain binary.
- R7: When control bit 1 is 1, hours read and write as 0..23. When it is 0, the hour byte holds 1..12 in bits 6:0 and bit 7 is set for PM. Hour 0 is shown as 12 with bit 7 clear, and hour 12 as 12 with bit 7 set.
- R8: With bit 0 set, a tick at 01:59:59 on a Sunday in April with date 1..7 moves the time to 03:00:00. On other dates the time moves to 02:00:00 as usual.
- R9: With bit 0 set, the first tick at 01:59:59 on a Sunday in October with date 25..31 moves the time to 01:00:00. Any later pass through 01:59:59 before midnight moves the time to 02:00:00.
- R10: A write to a time byte loads that counter and does not touch the buffer until the next transfer. If the write falls in the same clock as a tick, the written field takes the written value and the other fields advance as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-clock pulse once per second |
| reg_we | input | 1 | Write strobe for the byte at `reg_addr` |
| reg_addr | input | ADDR_W | Register address, used for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| upd_done | output | 1 | One-clock pulse after each buffer transfer |

## Verification
The main overlap is a host write to a time byte landing in the same clock as a second tick. In that clock the written value must replace only its own field, after the carry from the tick has already been applied to the fields above it. The bench provokes this by pulsing the write and the tick together, once on a plain second and once when the seconds are at 59, so that the overwritten minute competes with a carry. A behavioural model applies "advance, then overwrite" and is compared against the read data and the pulse on every clock. A control write that sets the inhibit bit in the same clock as a tick is judged by the same model. The tick in that clock still transfers, because it sees the old inhibit value.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int BYTE_W    = 8;
  localparam int ADR_SEC   = 0;
  localparam int ADR_MIN   = 1;
  localparam int ADR_HOUR  = 2;
  localparam int ADR_DOW   = 3;
  localparam int ADR_DATE  = 4;
  localparam int ADR_MONTH = 5;
  localparam int ADR_YEAR  = 6;
  localparam int ADR_CTRL  = 7;

  localparam int CB_INH = 7;
  localparam int CB_UIE = 4;
  localparam int CB_RSV = 3;
  localparam int CB_DF  = 2;
  localparam int CB_HF  = 1;
  localparam int CB_DSE = 0;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [2:0] dow;
    logic [4:0] date;
    logic [3:0] month;
    logic [6:0] year;
  } cal_time_t;

  localparam cal_time_t CAL_RESET = '{sec: 6'd0, min: 6'd0, hour: 5'd0, dow: 3'd1,
                                      date: 5'd1, month: 4'd1, year: 7'd0};

  // binary value 0..99 to presentation byte
  function automatic logic [7:0] enc_num(input logic [6:0] v, input logic bin);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / 7'd10);
    ones = 4'(v % 7'd10);
    return bin ? {1'b0, v} : {tens, ones};
  endfunction

  // presentation byte to binary value
  function automatic logic [6:0] dec_num(input logic [7:0] d, input logic bin);
    return bin ? d[6:0] : 7'(7'(d[7:4]) * 7'd10 + 7'(d[3:0]));
  endfunction

  function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin, input logic h24);
    logic [6:0] h12;
    logic [7:0] t;
    if (h24) return enc_num({2'b00, h}, bin);
    if (h == 5'd0)       h12 = 7'd12;
    else if (h > 5'd12)  h12 = {2'b00, h - 5'd12};
    else                 h12 = {2'b00, h};
    t = enc_num(h12, bin);
    return {(h >= 5'd12), t[6:0]};
  endfunction

  function automatic logic [4:0] dec_hour(input logic [7:0] d, input logic bin, input logic h24);
    logic [6:0] v;
    logic [4:0] base;
    if (h24) begin
      v = dec_num(d, bin);
      return v[4:0];
    end
    v    = dec_num({1'b0, d[6:0]}, bin);
    base = (v == 7'd12) ? 5'd0 : v[4:0];
    return base + (d[7] ? 5'd12 : 5'd0);
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] m, input logic [6:0] y, input int leap_div);
    case (m)
      4'd2:                   return ((int'(y) % leap_div) == 0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              inh,
  output logic              bin,
  output logic              h24,
  output logic              dse
);

  logic [BYTE_W-1:0] ctrl_nx;

  always_comb begin
    ctrl_nx         = wr_data;
    ctrl_nx[CB_RSV] = 1'b0;
    if (ctrl_nx[CB_INH]) ctrl_nx[CB_UIE] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                                      ctrl_q <= '0;
    else if (wr_en && addr == ADDR_W'(ADR_CTRL))  ctrl_q <= ctrl_nx;
  end

  assign inh = ctrl_q[CB_INH];
  assign bin = ctrl_q[CB_DF];
  assign h24 = ctrl_q[CB_HF];
  assign dse = ctrl_q[CB_DSE];

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int LEAP_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              dse,
  input  logic              bin,
  input  logic              h24,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output cal_time_t         cur_q,
  output cal_time_t         nxt
);

  logic       fb_q, fb_nx;
  logic       top_of_hour, at_one, sunday, spring, fall;
  logic [6:0] wv;
  logic [4:0] wh;

  assign top_of_hour = (cur_q.sec == 6'd59) && (cur_q.min == 6'd59);
  assign at_one      = (cur_q.hour == 5'd1);
  assign sunday      = (cur_q.dow == 3'd1);
  assign spring      = dse && sunday && at_one && (cur_q.month == 4'd4) && (cur_q.date <= 5'd7);
  assign fall        = dse && sunday && at_one && (cur_q.month == 4'd10) && (cur_q.date >= 5'd25) && !fb_q;

  assign wv = dec_num(wr_data, bin);
  assign wh = dec_hour(wr_data, bin, h24);

  always_comb begin
    nxt   = cur_q;
    fb_nx = fb_q;
    if (tick) begin
      if (cur_q.sec != 6'd59) begin
        nxt.sec = cur_q.sec + 6'd1;
      end else begin
        nxt.sec = 6'd0;
        if (cur_q.min != 6'd59) begin
          nxt.min = cur_q.min + 6'd1;
        end else begin
          nxt.min = 6'd0;
          if (top_of_hour && spring) begin
            nxt.hour = 5'd3;
          end else if (top_of_hour && fall) begin
            nxt.hour = 5'd1;
            fb_nx    = 1'b1;
          end else if (cur_q.hour != 5'd23) begin
            nxt.hour = cur_q.hour + 5'd1;
          end else begin
            nxt.hour = 5'd0;
            fb_nx    = 1'b0;
            nxt.dow  = (cur_q.dow == 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
            if (cur_q.date != month_days(cur_q.month, cur_q.year, LEAP_DIV)) begin
              nxt.date = cur_q.date + 5'd1;
            end else begin
              nxt.date = 5'd1;
              if (cur_q.month != 4'd12) begin
                nxt.month = cur_q.month + 4'd1;
              end else begin
                nxt.month = 4'd1;
                nxt.year  = (cur_q.year == 7'd99) ? 7'd0 : cur_q.year + 7'd1;
              end
            end
          end
        end
      end
    end
    if (wr_en) begin
      case (addr)
        ADDR_W'(ADR_SEC):   nxt.sec   = wv[5:0];
        ADDR_W'(ADR_MIN):   nxt.min   = wv[5:0];
        ADDR_W'(ADR_HOUR):  nxt.hour  = wh;
        ADDR_W'(ADR_DOW):   nxt.dow   = wv[2:0];
        ADDR_W'(ADR_DATE):  nxt.date  = wv[4:0];
        ADDR_W'(ADR_MONTH): nxt.month = wv[3:0];
        ADDR_W'(ADR_YEAR):  nxt.year  = wv;
        default:            ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= CAL_RESET;
      fb_q  <= 1'b0;
    end else begin
      cur_q <= nxt;
      fb_q  <= fb_nx;
    end
  end

endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              inh,
  input  logic              bin,
  input  logic              h24,
  input  cal_time_t         nxt,
  input  logic [BYTE_W-1:0] ctrl_q,
  input  logic [ADDR_W-1:0] addr,
  output cal_time_t         buf_q,
  output logic [BYTE_W-1:0] rd_data,
  output logic              upd_done
);

  logic [BYTE_W-1:0] rd_nx;
  logic              xfer;

  assign xfer = tick && !inh;

  always_comb begin
    case (addr)
      ADDR_W'(ADR_SEC):   rd_nx = enc_num({1'b0, buf_q.sec}, bin);
      ADDR_W'(ADR_MIN):   rd_nx = enc_num({1'b0, buf_q.min}, bin);
      ADDR_W'(ADR_HOUR):  rd_nx = enc_hour(buf_q.hour, bin, h24);
      ADDR_W'(ADR_DOW):   rd_nx = enc_num({4'b0, buf_q.dow}, bin);
      ADDR_W'(ADR_DATE):  rd_nx = enc_num({2'b0, buf_q.date}, bin);
      ADDR_W'(ADR_MONTH): rd_nx = enc_num({3'b0, buf_q.month}, bin);
      ADDR_W'(ADR_YEAR):  rd_nx = enc_num(buf_q.year, bin);
      ADDR_W'(ADR_CTRL):  rd_nx = ctrl_q;
      default:            rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q    <= CAL_RESET;
      rd_data  <= '0;
      upd_done <= 1'b0;
    end else begin
      if (xfer) buf_q <= nxt;
      upd_done <= xfer;
      rd_data  <= rd_nx;
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int LEAP_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              upd_done
);

  logic [BYTE_W-1:0] ctrl_q;
  logic              inh, bin, h24, dse;
  cal_time_t         cur_q, nxt, buf_q;

  rtc_ctrl_reg #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(reg_we), .addr(reg_addr), .wr_data(reg_wdata),
    .ctrl_q(ctrl_q), .inh(inh), .bin(bin), .h24(h24), .dse(dse)
  );

  rtc_timekeeper #(.ADDR_W(ADDR_W), .LEAP_DIV(LEAP_DIV)) u_time (
    .clk(clk), .rst(rst), .tick(sec_tick), .dse(dse), .bin(bin), .h24(h24),
    .wr_en(reg_we), .addr(reg_addr), .wr_data(reg_wdata), .cur_q(cur_q), .nxt(nxt)
  );

  rtc_shadow #(.ADDR_W(ADDR_W)) u_shadow (
    .clk(clk), .rst(rst), .tick(sec_tick), .inh(inh), .bin(bin), .h24(h24),
    .nxt(nxt), .ctrl_q(ctrl_q), .addr(reg_addr), .buf_q(buf_q),
    .rd_data(reg_rdata), .upd_done(upd_done)
  );

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       sec_tick,
  input logic       reg_we,
  input logic       upd_done,
  input logic [7:0] ctrl_q,
  input cal_time_t  cur_q,
  input cal_time_t  buf_q
);

  AST_TIME_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cur_q.sec < 6'd60 && cur_q.min < 6'd60 && cur_q.hour < 5'd24 &&
    cur_q.dow >= 3'd1 && cur_q.dow <= 3'd7 && cur_q.date >= 5'd1) // R1
    else $error("AST_TIME_IN_RANGE");

  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    upd_done |-> ($past(sec_tick) && !$past(ctrl_q[7]))) // R2
    else $error("AST_PULSE_NEEDS_TICK");

  AST_TICK_GIVES_PULSE: assert property (@(posedge clk) disable iff (rst)
    ($past(sec_tick) && !$past(ctrl_q[7]) && !$past(rst)) |-> upd_done) // R2
    else $error("AST_TICK_GIVES_PULSE");

  AST_BUF_HELD_INHIBIT: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_q[7]) && !$past(rst)) |-> $stable(buf_q)) // R3
    else $error("AST_BUF_HELD_INHIBIT");

  AST_INH_CLEARS_UIE: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[7] |-> !ctrl_q[4]) // R4
    else $error("AST_INH_CLEARS_UIE");

  AST_RSV_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[3]) // R5
    else $error("AST_RSV_BIT_ZERO");

  AST_SPRING_SKIPS_TWO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sec_tick) && !$past(reg_we) && $past(cur_q.hour) == 5'd1 && cur_q.hour == 5'd2)
    |-> !($past(ctrl_q[0]) && $past(cur_q.month) == 4'd4 && $past(cur_q.dow) == 3'd1 && $past(cur_q.date) <= 5'd7)) // R8
    else $error("AST_SPRING_SKIPS_TWO");

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .reg_we(reg_we), .upd_done(upd_done),
  .ctrl_q(ctrl_q), .cur_q(cur_q), .buf_q(buf_q)
);

// File: tb/sim_rtc_calendar.sv
`timescale 1ns/1ps
module sim_rtc_calendar;

  logic       clk = 1'b0;
  logic       rst;
  logic       sec_tick;
  logic       reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       upd_done;

  always #2.5 clk = ~clk;

  rtc_calendar u0 (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upd_done(upd_done)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    armed = 0;
  bit    done  = 0;
  string cur_req = "R5";

  // behavioural reference: index 0 sec,1 min,2 hour,3 dow,4 date,5 month,6 year
  int t[7];
  int b[7];
  int nt[7];
  int m_ctrl, m_fb, nfb, exp_rd, exp_upd;

  function automatic int enc(int v, int c);
    if (c & 4) return v;
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int dec(int d, int c);
    if (c & 4) return d;
    return (d >> 4) * 10 + (d & 15);
  endfunction

  function automatic int enc_hr(int h, int c);
    int h12;
    if (c & 2) return enc(h, c);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return enc(h12, c) + ((h >= 12) ? 128 : 0);
  endfunction

  function automatic int dec_hr(int d, int c);
    if (c & 2) return dec(d, c);
    return (dec(d & 127, c) % 12) + ((d & 128) ? 12 : 0);
  endfunction

  function automatic int mdays(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      t = '{0, 0, 0, 1, 1, 1, 0};
      b = t;
      m_ctrl = 0; m_fb = 0; exp_rd = 0; exp_upd = 0;
    end else begin
      if (reg_addr == 7)      exp_rd = m_ctrl;
      else if (reg_addr == 2) exp_rd = enc_hr(b[2], m_ctrl);
      else                    exp_rd = enc(b[reg_addr], m_ctrl);
      exp_upd = (sec_tick && !(m_ctrl & 128)) ? 1 : 0;
      nt = t; nfb = m_fb;
      if (sec_tick) begin
        nt[0] = t[0] + 1;
        if (nt[0] == 60) begin
          nt[0] = 0; nt[1] = t[1] + 1;
          if (nt[1] == 60) begin
            nt[1] = 0;
            if ((m_ctrl & 1) && t[5] == 4 && t[3] == 1 && t[4] <= 7 && t[2] == 1) nt[2] = 3;
            else if ((m_ctrl & 1) && t[5] == 10 && t[3] == 1 && t[4] + 7 > 31 && t[2] == 1 && !m_fb) begin
              nt[2] = 1; nfb = 1;
            end else begin
              nt[2] = t[2] + 1;
              if (nt[2] == 24) begin
                nt[2] = 0; nfb = 0;
                nt[3] = t[3] % 7 + 1;
                nt[4] = t[4] + 1;
                if (nt[4] > mdays(t[5], t[6])) begin
                  nt[4] = 1;
                  nt[5] = t[5] % 12 + 1;
                  if (nt[5] == 1) nt[6] = (t[6] + 1) % 100;
                end
              end
            end
          end
        end
      end
      if (reg_we) begin
        if (reg_addr == 7) begin
          m_ctrl = reg_wdata & 8'hF7;
          if (m_ctrl & 128) m_ctrl = m_ctrl & 8'hEF;
        end else if (reg_addr == 2) nt[2] = dec_hr(reg_wdata, m_ctrl);
        else                        nt[reg_addr] = dec(reg_wdata, m_ctrl);
      end
      if (sec_tick && !(m_ctrl_old_inh())) b = nt;
      t = nt; m_fb = nfb;
    end
  end

  // inhibit as seen before this edge: exp_upd already captured it
  function automatic bit m_ctrl_old_inh();
    return (exp_upd == 0);
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (armed && !done) begin
      n_cmp++;
      if (reg_rdata !== 8'(exp_rd)) begin
        n_bad++;
        $display("FAIL %s model rdata: got %h expected %h", cur_req, reg_rdata, 8'(exp_rd));
      end
      n_cmp++;
      if (upd_done !== 1'(exp_upd)) begin
        n_bad++;
        $display("FAIL %s model upd_done: got %0d expected %0d", cur_req, upd_done, exp_upd);
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); reg_we = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    @(negedge clk); reg_addr = 3'(a);
    @(negedge clk); chk(tag, reg_rdata, exp);
  endtask

  task automatic tick_p(string tag, int exp);
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0; chk(tag, upd_done, exp);
    @(negedge clk); chk({tag, " pulse width"}, upd_done, 0);
  endtask

  task automatic tick_wr(int a, int d);
    @(negedge clk); sec_tick = 1; reg_we = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk); sec_tick = 0; reg_we = 0;
    @(negedge clk);
  endtask

  task automatic set_time(int yr, int mo, int dt, int dw, int hr, int mi, int se);
    wr(6, yr); wr(5, mo); wr(4, dt); wr(3, dw); wr(2, hr); wr(1, mi); wr(0, se);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1; sec_tick = 0; reg_we = 0; reg_addr = 3'd7; reg_wdata = 8'd0;
    repeat (4) @(negedge clk);
    rst = 0; armed = 1;

    cur_req = "R5";
    rd_chk("R5 reset control", 7, 8'h00);
    chk("R2 reset upd_done", upd_done, 0);
    rd_chk("R6 reset seconds", 0, 8'h00);

    cur_req = "R4";
    wr(7, 8'hFF); rd_chk("R4 inhibit clears update enable", 7, 8'hE7);
    cur_req = "R5";
    wr(7, 8'h7F); rd_chk("R5 read back minus bit 3", 7, 8'h77);

    cur_req = "R1";
    wr(7, 8'h06);
    set_time(23, 2, 28, 3, 23, 59, 58);
    tick_p("R2 transfer pulse", 1);
    tick_p("R2 transfer pulse", 1);
    rd_chk("R1 hour wrap", 2, 0);
    rd_chk("R1 Feb 28 non-leap wraps", 4, 1);
    rd_chk("R1 month advance", 5, 3);
    rd_chk("R1 dow advance", 3, 4);
    set_time(24, 2, 28, 3, 23, 59, 59);
    tick_p("R2", 1);
    rd_chk("R1 leap Feb 29", 4, 29);
    wr(2, 23); wr(1, 59); wr(0, 59);
    tick_p("R2", 1);
    rd_chk("R1 leap Feb 29 wraps", 4, 1);
    rd_chk("R1 leap month", 5, 3);
    set_time(99, 12, 31, 7, 23, 59, 59);
    tick_p("R2", 1);
    rd_chk("R1 year wrap", 6, 0);
    rd_chk("R1 month wrap", 5, 1);
    rd_chk("R1 dow 7 to 1", 3, 1);

    cur_req = "R6";
    wr(7, 8'h00);
    wr(0, 8'h45); wr(1, 8'h30); wr(2, 8'h92);
    tick_p("R2", 1);
    rd_chk("R6 BCD seconds", 0, 8'h46);
    rd_chk("R6 BCD minutes", 1, 8'h30);
    cur_req = "R7";
    rd_chk("R7 noon 12h BCD", 2, 8'h92);
    wr(7, 8'h02); rd_chk("R7 noon 24h BCD", 2, 8'h12);
    wr(7, 8'h06); rd_chk("R7 noon 24h binary", 2, 8'h0C);
    rd_chk("R6 binary seconds", 0, 8'h2E);
    wr(7, 8'h04); rd_chk("R7 noon 12h binary", 2, 8'h8C);
    wr(2, 8'h8B);
    tick_p("R2", 1);
    wr(7, 8'h02); rd_chk("R7 11 PM shown as 23", 2, 8'h23);
    wr(7, 8'h00); wr(2, 8'h12);
    tick_p("R2", 1);
    rd_chk("R7 midnight 12 AM", 2, 8'h12);
    wr(7, 8'h06); rd_chk("R7 midnight 24h", 2, 0);

    cur_req = "R3";
    wr(0, 10);
    tick_p("R2", 1);
    rd_chk("R3 before inhibit", 0, 11);
    wr(7, 8'h96); rd_chk("R4 written with inhibit", 7, 8'h86);
    tick_p("R3 no pulse while inhibited", 0);
    tick_p("R3 no pulse while inhibited", 0);
    tick_p("R3 no pulse while inhibited", 0);
    rd_chk("R3 buffer held", 0, 11);
    wr(7, 8'h06);
    tick_p("R3 resumed", 1);
    rd_chk("R3 counters kept running", 0, 15);

    cur_req = "R8";
    wr(7, 8'h07);
    set_time(24, 4, 7, 1, 1, 59, 59);
    tick_p("R2", 1);
    rd_chk("R8 spring to 3", 2, 3);
    rd_chk("R8 spring minutes", 1, 0);
    set_time(24, 4, 14, 1, 1, 59, 59);
    tick_p("R2", 1);
    rd_chk("R8 second Sunday normal", 2, 2);
    wr(7, 8'h06);
    set_time(24, 4, 7, 1, 1, 59, 59);
    tick_p("R2", 1);
    rd_chk("R8 disabled normal", 2, 2);

    cur_req = "R9";
    wr(7, 8'h07);
    set_time(24, 10, 27, 1, 1, 59, 59);
    tick_p("R2", 1);
    rd_chk("R9 fall back to 1", 2, 1);
    rd_chk("R9 fall back minutes", 1, 0);
    wr(1, 59); wr(0, 59);
    tick_p("R2", 1);
    rd_chk("R9 second pass continues", 2, 2);
    wr(2, 1); wr(1, 59); wr(0, 59);
    tick_p("R2", 1);
    rd_chk("R9 only once per night", 2, 2);
    wr(6, 24); wr(5, 10); wr(4, 20); wr(3, 1); wr(2, 23); wr(1, 59); wr(0, 59);
    tick_p("R2", 1);
    wr(2, 1); wr(1, 59); wr(0, 59);
    tick_p("R2", 1);
    rd_chk("R9 not last Sunday", 2, 2);

    cur_req = "R10";
    wr(7, 8'h06);
    wr(2, 5); wr(1, 30); wr(0, 20);
    tick_p("R2", 1);
    tick_wr(0, 10);
    rd_chk("R10 write wins over tick", 0, 10);
    rd_chk("R10 other fields intact", 1, 30);
    wr(0, 40);
    rd_chk("R10 write waits for transfer", 0, 10);
    wr(0, 59);
    tick_wr(1, 7);
    rd_chk("R10 written minute beats carry", 1, 7);
    rd_chk("R10 seconds carried", 0, 0);
    rd_chk("R10 hour unchanged", 2, 5);

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule